// File: doc/BRIEF.md
# Floating-Point Condition-Code Comparator

This block orders two single-precision floating-point words and reports the result as a 4-bit condition code, laid out as N, Z, C, V from the most significant bit down, together with an invalid-operation flag. It never unpacks the operands into exponent and significand arithmetic. It first classifies each word (NaN, signalling NaN, zero magnitude, sign). It then derives the ordering from an integer comparison of the raw words, and reverses the sense of that comparison when both operands are negative.

Two mode bits go with each request. The first makes a quiet NaN raise invalid as well as a signalling one. The second replaces the second operand with positive zero, so a value can be tested against zero without supplying a constant. A request is taken on the clock edge where the valid strobe is high. The condition code and the invalid flag are registered and appear on the next cycle with an output valid pulse. They keep their value until the next request.

Top module: `fcmp_nzcv_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, out_valid, out_nzcv and out_invalid are all zero.
- R2: out_valid is high exactly in the cycle after a cycle with in_valid high. out_nzcv and out_invalid change only at those edges and otherwise hold their last value.
- R3: A word is a NaN when bits 30:23 are all ones and bits 22:0 are not all zero. If either operand is a NaN, the code is unordered, 4'b0011 (C and V).
- R4: out_invalid is set for an unordered result when a NaN operand has bit 22 clear (signalling), or when sig_quiet is high and any operand is a NaN. It is clear for every ordered result.
- R5: Identical words, or two operands with bits 30:0 zero whatever their signs, give equal, 4'b0110 (Z and C).
- R6: When the signs (bit 31) differ and the result is not equal, the code is less, 4'b1000 (N), if the first operand is negative, and greater, 4'b0010 (C), otherwise.
- R7: When both operands are positive and not equal, the code is less if the first word is below the second as an unsigned integer, and greater otherwise. Infinities (bits 30:23 all ones, bits 22:0 zero) take part as ordinary values.
- R8: When both operands are negative and not equal, the unsigned word comparison is inverted: a larger first word gives less, and a smaller one gives greater.
- R9: With vs_zero high the second operand is +0 (0x00000000), and the value on in_m has no effect on the code or the invalid flag.
- R10: Every reported code is exactly one of equal, less, greater or unordered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; operands and modes are sampled at this edge |
| in_d | input | 32 | First operand, packed single precision |
| in_m | input | 32 | Second operand, packed single precision |
| sig_quiet | input | 1 | When high, a quiet NaN also raises invalid |
| vs_zero | input | 1 | When high, compare against +0 instead of in_m |
| out_valid | output | 1 | Pulses one cycle after a request |
| out_nzcv | output | 4 | Condition code {N,Z,C,V} |
| out_invalid | output | 1 | Invalid-operation flag for the last request |

## Verification
On every cycle the assertions check the one-cycle latency and the hold between requests. They also check that each code is one of the four legal outcomes, that invalid never goes with an ordered code, and that a NaN or identical words at the input lead to unordered or equal on the next cycle. Only the bench scenarios can show the ordering itself: signed zeros, mixed signs, the reversed sense for two negatives, infinities, and the quiet-versus-signalling split under each mode. They also show that in_m is ignored in compare-with-zero mode. Those results are compared with an independent sign-magnitude model on every clock.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int unsigned FCMP_EXP_W = 8;
    localparam int unsigned FCMP_MAN_W = 23;

    typedef enum logic [3:0] {
        CC_NONE = 4'b0000,
        CC_EQ   = 4'b0110,
        CC_LT   = 4'b1000,
        CC_GT   = 4'b0010,
        CC_UN   = 4'b0011
    } cc_code_t;

    typedef struct packed {
        logic sign;
        logic is_nan;
        logic is_snan;
        logic is_zero;
    } op_class_t;

    typedef struct packed {
        cc_code_t code;
        logic     invalid;
    } cmp_result_t;

    function automatic logic code_is_legal(input logic [3:0] c);
        return (c == CC_EQ) || (c == CC_LT) || (c == CC_GT) || (c == CC_UN);
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int unsigned EXP_W = FCMP_EXP_W,
    parameter int unsigned MAN_W = FCMP_MAN_W
) (
    input  logic [EXP_W+MAN_W:0] word,
    output op_class_t            cls
);
    localparam int unsigned WORD_W = EXP_W + MAN_W + 1;
    localparam int unsigned QBIT   = MAN_W - 1;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    assign exp_f = word[WORD_W-2 -: EXP_W];
    assign man_f = word[MAN_W-1:0];

    always_comb begin
        cls.sign    = word[WORD_W-1];
        cls.is_nan  = (&exp_f) && (|man_f);
        cls.is_snan = cls.is_nan && !man_f[QBIT];
        cls.is_zero = ~|word[WORD_W-2:0];
    end

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int unsigned WORD_W = FCMP_EXP_W + FCMP_MAN_W + 1
) (
    input  logic [WORD_W-1:0] d_word,
    input  logic [WORD_W-1:0] m_word,
    input  op_class_t         d_cls,
    input  op_class_t         m_cls,
    input  logic              sig_quiet,
    output cmp_result_t       res
);
    localparam int unsigned MAG_W = WORD_W - 1;

    logic mag_below;
    logic unordered;
    logic same_value;

    assign mag_below  = d_word[MAG_W-1:0] < m_word[MAG_W-1:0];
    assign unordered  = d_cls.is_nan || m_cls.is_nan;
    assign same_value = (d_word == m_word) || (d_cls.is_zero && m_cls.is_zero);

    always_comb begin
        res.invalid = 1'b0;
        if (unordered) begin
            res.code    = CC_UN;
            res.invalid = d_cls.is_snan || m_cls.is_snan || sig_quiet;
        end else if (same_value) begin
            res.code = CC_EQ;
        end else if (d_cls.sign != m_cls.sign) begin
            res.code = d_cls.sign ? CC_LT : CC_GT;
        end else if (mag_below ^ d_cls.sign) begin
            res.code = CC_LT;
        end else begin
            res.code = CC_GT;
        end
    end

endmodule

// File: rtl/fcmp_nzcv_unit.sv
module fcmp_nzcv_unit
    import fcmp_pkg::*;
#(
    parameter int unsigned EXP_W = FCMP_EXP_W,
    parameter int unsigned MAN_W = FCMP_MAN_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [EXP_W+MAN_W:0]    in_d,
    input  logic [EXP_W+MAN_W:0]    in_m,
    input  logic                    sig_quiet,
    input  logic                    vs_zero,
    output logic                    out_valid,
    output logic [3:0]              out_nzcv,
    output logic                    out_invalid
);
    localparam int unsigned WORD_W = EXP_W + MAN_W + 1;
    localparam int unsigned N_OPS  = 2;

    logic [WORD_W-1:0] op_word [N_OPS];
    op_class_t         op_cls  [N_OPS];
    cmp_result_t       next_res;
    cmp_result_t       res_q;
    logic              valid_q;

    assign op_word[0] = in_d;
    assign op_word[1] = vs_zero ? '0 : in_m;

    for (genvar g = 0; g < N_OPS; g++) begin : g_cls
        fcmp_classify #(
            .EXP_W (EXP_W),
            .MAN_W (MAN_W)
        ) i_cls (
            .word (op_word[g]),
            .cls  (op_cls[g])
        );
    end

    fcmp_order #(
        .WORD_W (WORD_W)
    ) i_order (
        .d_word    (op_word[0]),
        .m_word    (op_word[1]),
        .d_cls     (op_cls[0]),
        .m_cls     (op_cls[1]),
        .sig_quiet (sig_quiet),
        .res       (next_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '{code: CC_NONE, invalid: 1'b0};
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                res_q <= next_res;
            end
        end
    end

    assign out_valid   = valid_q;
    assign out_nzcv    = res_q.code;
    assign out_invalid = res_q.invalid;

endmodule

// File: rtl/fcmp_nzcv_chk.sv
module fcmp_nzcv_chk
    import fcmp_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] in_d,
    input logic [31:0] in_m,
    input logic        sig_quiet,
    input logic        vs_zero,
    input logic        out_valid,
    input logic [3:0]  out_nzcv,
    input logic        out_invalid
);
    logic d_nan;
    assign d_nan = (&in_d[30:23]) && (|in_d[22:0]);

    // R2
    req_latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    idle_latency_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R2
    hold_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_nzcv) && $stable(out_invalid)));

    // R10
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> code_is_legal(out_nzcv));

    // R4
    invalid_only_unordered_chk: assert property (@(posedge clk) disable iff (rst)
        out_invalid |-> (out_nzcv == 4'b0011));

    // R3
    nan_unordered_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && d_nan) |=> (out_nzcv == 4'b0011));

    // R5
    same_word_eq_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !vs_zero && !d_nan && in_d == in_m) |=> (out_nzcv == 4'b0110 && !out_invalid));

endmodule

bind fcmp_nzcv_unit fcmp_nzcv_chk i_fcmp_nzcv_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_d        (in_d),
    .in_m        (in_m),
    .sig_quiet   (sig_quiet),
    .vs_zero     (vs_zero),
    .out_valid   (out_valid),
    .out_nzcv    (out_nzcv),
    .out_invalid (out_invalid)
);

// File: tb/test_fcmp_nzcv_unit.sv
module test_fcmp_nzcv_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_d = '0;
    logic [31:0] in_m = '0;
    logic        sig_quiet = 1'b0;
    logic        vs_zero = 1'b0;
    logic        out_valid;
    logic [3:0]  out_nzcv;
    logic        out_invalid;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    fcmp_nzcv_unit i_fcmp_nzcv_unit (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_d        (in_d),
        .in_m        (in_m),
        .sig_quiet   (sig_quiet),
        .vs_zero     (vs_zero),
        .out_valid   (out_valid),
        .out_nzcv    (out_nzcv),
        .out_invalid (out_invalid)
    );

    // ---------------- reference model ----------------
    logic        exp_valid = 1'b0;
    logic [3:0]  exp_nzcv  = 4'b0000;
    logic        exp_inv   = 1'b0;
    string       exp_tag   = "R1";

    function automatic bit is_nan(input logic [31:0] w);
        return (w[30:23] == 8'hFF) && (w[22:0] != 0);
    endfunction

    function automatic longint to_key(input logic [31:0] w);
        longint mag = longint'(w[30:0]);
        return w[31] ? -mag : mag;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            exp_valid <= 1'b0;
            exp_nzcv  <= 4'b0000;
            exp_inv   <= 1'b0;
            exp_tag   <= "R1";
        end else begin
            exp_valid <= in_valid;
            if (in_valid) begin
                logic [31:0] b;
                longint ka, kb;
                b = vs_zero ? 32'h0 : in_m;
                ka = to_key(in_d);
                kb = to_key(b);
                if (is_nan(in_d) || is_nan(b)) begin
                    exp_nzcv <= 4'b0011;
                    exp_inv  <= sig_quiet || (is_nan(in_d) && !in_d[22]) || (is_nan(b) && !b[22]);
                    exp_tag  <= "R3";
                end else begin
                    exp_inv  <= 1'b0;
                    exp_nzcv <= (ka == kb) ? 4'b0110 : (ka < kb) ? 4'b1000 : 4'b0010;
                    if (vs_zero)                   exp_tag <= "R9";
                    else if (ka == kb)             exp_tag <= "R5";
                    else if (in_d[31] != b[31])    exp_tag <= "R6";
                    else if (in_d[31])             exp_tag <= "R8";
                    else                           exp_tag <= "R7";
                end
            end else begin
                exp_tag <= "R2";
            end
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check(rst ? "R1" : "R2", "out_valid", int'(out_valid), int'(exp_valid));
            check(exp_tag, "out_nzcv", int'(out_nzcv), int'(exp_nzcv));
            check(rst ? "R1" : "R4", "out_invalid", int'(out_invalid), int'(exp_inv));
            if (out_valid) begin
                // R10: one of equal / less / greater / unordered
                check("R10", "code legal", int'(out_nzcv == 4'b0110 || out_nzcv == 4'b1000 ||
                      out_nzcv == 4'b0010 || out_nzcv == 4'b0011), 1);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic apply(input logic [31:0] d, input logic [31:0] m,
                         input logic q, input logic z);
        in_valid  = 1'b1;
        in_d      = d;
        in_m      = m;
        sig_quiet = q;
        vs_zero   = z;
        @(negedge clk);
        in_valid  = 1'b0;
        in_d      = $urandom;
        in_m      = $urandom;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
            finish_run();
        end
    end

    initial begin
        idle(3);                                     // R1 reset state
        rst = 1'b0;
        idle(2);                                     // R1 first cycle after reset
        apply(32'h3F800000, 32'h40000000, 0, 0);     // R7 1 < 2
        apply(32'h40000000, 32'h3F800000, 0, 0);     // R7 2 > 1
        idle(3);                                     // R2 hold
        apply(32'hBF800000, 32'hC0000000, 0, 0);     // R8 -1 > -2
        apply(32'hC0000000, 32'hBF800000, 0, 0);     // R8 -2 < -1
        apply(32'h00000000, 32'h80000000, 0, 0);     // R5 +0 == -0
        apply(32'h80000000, 32'h00000000, 1, 0);     // R5 -0 == +0
        apply(32'h12345678, 32'h12345678, 0, 0);     // R5 identical
        apply(32'hBF800000, 32'h3F800000, 0, 0);     // R6 -1 < 1
        apply(32'h3F800000, 32'hBF800000, 0, 0);     // R6 1 > -1
        apply(32'h7FC00000, 32'h3F800000, 0, 0);     // R3 qNaN, R4 no invalid
        apply(32'h7FC00000, 32'h3F800000, 1, 0);     // R4 qNaN with sig_quiet
        apply(32'h3F800000, 32'h7F800001, 0, 0);     // R4 sNaN in m
        apply(32'hFFA00000, 32'hFFC00000, 0, 0);     // R4 sNaN in d
        apply(32'h7F800000, 32'h7F7FFFFF, 0, 0);     // R7 +inf > max
        apply(32'hFF800000, 32'hFF7FFFFF, 0, 0);     // R8 -inf < -max
        apply(32'h7F800000, 32'h7F800000, 0, 0);     // R5 inf == inf
        apply(32'h3F800000, 32'h7FC00000, 1, 1);     // R9 m NaN ignored
        apply(32'h80000000, 32'hBF800000, 0, 1);     // R9 -0 vs +0 equal
        apply(32'h80000001, 32'h00000000, 0, 1);     // R9 -denorm < 0
        apply(32'h7FC00001, 32'h00000000, 0, 1);     // R9 NaN d still unordered
        idle(2);
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = $urandom;
            if (i % 5 == 0) b = a;
            if (i % 7 == 0) a[30:23] = 8'hFF;
            if (i % 11 == 0) b = {~a[31], a[30:0]};
            apply(a, b, 1'($urandom), 1'(i % 9 == 0));
            if (i % 4 == 0) idle(1);
        end
        rst = 1'b1;                                  // R1 reset mid-run
        idle(2);
        rst = 1'b0;
        idle(2);
        finish_run();
    end

endmodule